// File: doc/BRIEF.md
# Zero-Crossing Gated Stereo Gain Updater

This block sits between the held volume codes of a two-channel attenuator and the gain codes that the analog stage actually uses. When a new pair of codes is committed, it does not pass them on at once. Each channel holds its new code as a pending target. The target is applied only after that channel's audio has crossed zero twice, so the step in gain lands where the signal is near zero and makes no click.

Each channel sees its own sign bit from an external comparator, and the two channels are handled independently. One timer is shared by both channels. It starts at each commit and forces any target still pending after a set number of clock cycles. An enable input switches the whole mechanism off: with it low, codes are applied on the next clock edge and nothing is held.

Codes are 8 bits and are passed through unchanged. 0xFF is the top gain, 0xC0 is unity, each step is half a decibel, and 0x00 is mute.

Top module: `zc_gain_updater`

## Requirements
- R1: During and after reset, both applied gain codes are 0x00 and both pending flags are low.
- R2: With zc_en_i low, a load_i pulse sampled at a clock edge places code_l_i and code_r_i on gain_l_o and gain_r_o at that same edge, and neither pending flag is raised.
- R3: With zc_en_i high, a load_i pulse stores both codes as targets and raises both pending flags at the sampled edge, and the applied gains stay unchanged.
- R4: A pending target is applied on a channel only at its second zero crossing counted after the latest load. A single crossing is not enough. Crossings on one channel have no effect on the other channel.
- R5: A zero crossing is any change of the channel's sign input, rising or falling, seen after a two-stage synchronizer. Crossings that happen while nothing is pending are ignored and are not carried into a later load.
- R6: A target that is still pending is applied at exactly TIMEOUT_CYC clock edges after the load edge, on every channel that is still pending.
- R7: A load while a change is pending replaces the target, clears the crossing count and restarts the shared timer. The earlier target is never applied.
- R8: A channel's pending flag goes low on the same edge at which its applied gain takes the target.
- R9: Codes are passed through bit for bit, including 0x00 (mute) and 0xFF (top gain).
- R10: If zc_en_i goes low while a target is pending, the target is applied at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| zc_en_i | input | 1 | Enables zero-crossing gating and the timeout |
| load_i | input | 1 | One-cycle strobe: new codes are held |
| code_l_i | input | CODE_W | Held left code |
| code_r_i | input | CODE_W | Held right code |
| sign_l_i | input | 1 | Left comparator sign bit (asynchronous) |
| sign_r_i | input | 1 | Right comparator sign bit (asynchronous) |
| gain_l_o | output | CODE_W | Applied left gain code |
| gain_r_o | output | CODE_W | Applied right gain code |
| pend_l_o | output | 1 | Left change waiting |
| pend_r_o | output | 1 | Right change waiting |

## Verification
The bench checks that one crossing leaves the target pending. A design that applies on the first crossing would change the gain early. It then reloads between crossings: a design that keeps the old count would apply the second target after a single new crossing, and one that keeps the old timer would time out too soon. This second case is checked at the exact edge, one cycle before and at the limit. The bench also checks three further cases: crossings made while idle must not count toward a later load, crossings on one channel must not move the other, and dropping the enable must flush a pending target at once.

// File: rtl/zgu_pkg.sv
package zgu_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_L   = 0;
  localparam int unsigned CH_R   = 1;

  typedef enum logic [1:0] {
    APPLY_NONE,
    APPLY_DIRECT,
    APPLY_CROSS,
    APPLY_TIMEOUT
  } apply_cause_e;
endpackage

// File: rtl/zgu_sign_sync.sv
module zgu_sign_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sign_i,
  output logic cross_o
);
  // sh[STAGES-1] is the synchronized sign; sh[STAGES] holds its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], sign_i};
  end

  assign cross_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/zgu_timeout.sv
module zgu_timeout #(
  parameter int unsigned LIMIT = 3_600_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last  = (cnt_q == LAST);
  assign expire_o = run_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (restart_i)  cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!at_last)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/zgu_chan.sv
module zgu_chan
  import zgu_pkg::*;
#(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned CROSS_NEED = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              zc_en_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              cross_i,
  input  logic              expire_i,
  output logic [CODE_W-1:0] gain_o,
  output logic              pend_o
);
  localparam int unsigned CW = $clog2(CROSS_NEED + 1);
  localparam logic [CW-1:0] CW_LAST = CW'(CROSS_NEED - 1);

  logic [CODE_W-1:0] gain_q, tgt_q;
  logic              pend_q;
  logic [CW-1:0]     cnt_q;
  apply_cause_e      cause;

  always_comb begin
    cause = APPLY_NONE;
    if (load_i) begin
      if (!zc_en_i) cause = APPLY_DIRECT;
    end else if (pend_q) begin
      if (!zc_en_i)                          cause = APPLY_DIRECT;
      else if (cross_i && cnt_q == CW_LAST)  cause = APPLY_CROSS;
      else if (expire_i)                     cause = APPLY_TIMEOUT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= '0;
      tgt_q  <= '0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      if (!zc_en_i) begin
        gain_q <= code_i;
        pend_q <= 1'b0;
      end else begin
        tgt_q  <= code_i;
        pend_q <= 1'b1;
      end
    end else if (cause != APPLY_NONE) begin
      gain_q <= tgt_q;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pend_q && cross_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign gain_o = gain_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/zc_gain_updater.sv
module zc_gain_updater
  import zgu_pkg::*;
#(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CROSS_NEED  = 2,
  parameter int unsigned TIMEOUT_CYC = 3_600_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              zc_en_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_l_i,
  input  logic [CODE_W-1:0] code_r_i,
  input  logic              sign_l_i,
  input  logic              sign_r_i,
  output logic [CODE_W-1:0] gain_l_o,
  output logic [CODE_W-1:0] gain_r_o,
  output logic              pend_l_o,
  output logic              pend_r_o
);
  logic [NUM_CH-1:0][CODE_W-1:0] code_v, gain_v;
  logic [NUM_CH-1:0]             sign_v, cross_v, pend_v;
  logic                          expire;

  assign code_v[CH_L] = code_l_i;
  assign code_v[CH_R] = code_r_i;
  assign sign_v[CH_L] = sign_l_i;
  assign sign_v[CH_R] = sign_r_i;

  zgu_timeout #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (load_i && zc_en_i),
    .run_i     (|pend_v && zc_en_i),
    .expire_o  (expire)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    zgu_sign_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sign_i  (sign_v[ch]),
      .cross_o (cross_v[ch])
    );

    zgu_chan #(.CODE_W(CODE_W), .CROSS_NEED(CROSS_NEED)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .zc_en_i  (zc_en_i),
      .load_i   (load_i),
      .code_i   (code_v[ch]),
      .cross_i  (cross_v[ch]),
      .expire_i (expire),
      .gain_o   (gain_v[ch]),
      .pend_o   (pend_v[ch])
    );
  end

  assign gain_l_o = gain_v[CH_L];
  assign gain_r_o = gain_v[CH_R];
  assign pend_l_o = pend_v[CH_L];
  assign pend_r_o = pend_v[CH_R];
endmodule

// File: rtl/zgu_checker.sv
module zgu_checker #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              zc_en_i,
  input logic              load_i,
  input logic [CODE_W-1:0] code_l_i,
  input logic [CODE_W-1:0] code_r_i,
  input logic [CODE_W-1:0] gain_l_o,
  input logic [CODE_W-1:0] gain_r_o,
  input logic              pend_l_o,
  input logic              pend_r_o
);
  always_comb if (!rst_ni) begin
    AST_RESET_IDLE: assert (gain_l_o == '0 && gain_r_o == '0 && !pend_l_o && !pend_r_o); // R1
  end

  AST_BYPASS_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zc_en_i && load_i |=> gain_l_o == $past(code_l_i) && gain_r_o == $past(code_r_i) && !pend_l_o && !pend_r_o); // R2

  AST_LOAD_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zc_en_i && load_i |=> pend_l_o && pend_r_o && $stable(gain_l_o) && $stable(gain_r_o)); // R3

  AST_PEND_CLR_L: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gain_l_o) |-> !pend_l_o); // R8

  AST_PEND_CLR_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gain_r_o) |-> !pend_r_o); // R8

  AST_NO_SPONT_L: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gain_l_o) |-> $past(pend_l_o || load_i)); // R4

  AST_NO_SPONT_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gain_r_o) |-> $past(pend_r_o || load_i)); // R4

  AST_EN_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zc_en_i && !load_i && (pend_l_o || pend_r_o) |=> !pend_l_o && !pend_r_o); // R10
endmodule

bind zc_gain_updater zgu_checker #(.CODE_W(CODE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .zc_en_i  (zc_en_i),
  .load_i   (load_i),
  .code_l_i (code_l_i),
  .code_r_i (code_r_i),
  .gain_l_o (gain_l_o),
  .gain_r_o (gain_r_o),
  .pend_l_o (pend_l_o),
  .pend_r_o (pend_r_o)
);

// File: tb/zc_gain_updater_tb.sv
module zc_gain_updater_tb;
  localparam int unsigned T = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       zc_en = 1'b0, load = 1'b0, sg_l = 1'b0, sg_r = 1'b0;
  logic [7:0] code_l = '0, code_r = '0;
  logic [7:0] gain_l, gain_r;
  logic       pend_l, pend_r;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_l[$], exp_r[$];
  logic [7:0] prev_l = '0, prev_r = '0;

  always #2.5 clk = ~clk;

  zc_gain_updater #(.TIMEOUT_CYC(T)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .zc_en_i(zc_en), .load_i(load),
    .code_l_i(code_l), .code_r_i(code_r), .sign_l_i(sg_l), .sign_r_i(sg_r),
    .gain_l_o(gain_l), .gain_r_o(gain_r), .pend_l_o(pend_l), .pend_r_o(pend_r)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every change of an applied gain must match the next expected item
  always @(negedge clk) if (rst_n) begin
    if (gain_l != prev_l) begin
      if (exp_l.size() == 0) chk("R4 left unexpected update", {24'h0, gain_l}, 32'hFFFF_FFFF);
      else chk("R9 left applied code", {24'h0, gain_l}, {24'h0, exp_l.pop_front()});
    end
    if (gain_r != prev_r) begin
      if (exp_r.size() == 0) chk("R4 right unexpected update", {24'h0, gain_r}, 32'hFFFF_FFFF);
      else chk("R9 right applied code", {24'h0, gain_r}, {24'h0, exp_r.pop_front()});
    end
    prev_l = gain_l;
    prev_r = gain_r;
  end

  task automatic do_load(input logic [7:0] l, input logic [7:0] r);
    @(negedge clk);
    code_l = l; code_r = r; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic flip(input bit right);
    @(negedge clk);
    if (right) sg_r = ~sg_r; else sg_l = ~sg_l;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset gain_l", {24'h0, gain_l}, 32'h0);
    chk("R1 reset gain_r", {24'h0, gain_r}, 32'h0);
    chk("R1 reset pend", {30'h0, pend_l, pend_r}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // bypass
    exp_l.push_back(8'h55); exp_r.push_back(8'hAA);
    do_load(8'h55, 8'hAA);
    chk("R2 bypass gain_l", {24'h0, gain_l}, 32'h55);
    chk("R2 bypass gain_r", {24'h0, gain_r}, 32'hAA);
    chk("R2 bypass no pend", {30'h0, pend_l, pend_r}, 32'h0);

    // gated: two crossings per channel
    zc_en = 1'b1;
    do_load(8'hC0, 8'h10);
    chk("R3 pend both", {30'h0, pend_l, pend_r}, 32'h3);
    chk("R3 gain_l held", {24'h0, gain_l}, 32'h55);
    flip(1'b0);
    chk("R4 one crossing not enough", {31'h0, pend_l}, 32'h1);
    chk("R4 gain_l after one crossing", {24'h0, gain_l}, 32'h55);
    exp_l.push_back(8'hC0);
    flip(1'b0); // falling direction
    chk("R5 falling edge counts", {24'h0, gain_l}, 32'hC0);
    chk("R8 pend_l cleared", {31'h0, pend_l}, 32'h0);
    chk("R4 right independent", {23'h0, pend_r, gain_r}, 32'h1AA);
    flip(1'b1);
    exp_r.push_back(8'h10);
    flip(1'b1);
    chk("R4 right applied", {23'h0, pend_r, gain_r}, 32'h010);

    // timeout exact edge, mute and top codes
    do_load(8'hFF, 8'h00);
    repeat (T - 1) @(negedge clk);
    chk("R6 held before limit", {22'h0, pend_l, pend_r, gain_l}, 32'h3C0);
    exp_l.push_back(8'hFF); exp_r.push_back(8'h00);
    @(negedge clk);
    chk("R6 timeout applied left", {24'h0, gain_l}, 32'hFF);
    chk("R9 mute code passed", {24'h0, gain_r}, 32'h00);
    chk("R8 pend cleared on timeout", {30'h0, pend_l, pend_r}, 32'h0);

    // reload restarts crossing count
    do_load(8'h20, 8'h77);
    flip(1'b0);
    do_load(8'h30, 8'h78);
    flip(1'b0);
    chk("R7 count restarted", {31'h0, pend_l}, 32'h1);
    exp_l.push_back(8'h30);
    flip(1'b0);
    chk("R7 new target applied", {24'h0, gain_l}, 32'h30);
    exp_r.push_back(8'h78);
    repeat (T) @(negedge clk);
    chk("R7 right replaced target", {24'h0, gain_r}, 32'h78);

    // reload restarts timer
    do_load(8'h40, 8'h41);
    repeat (T - 10) @(negedge clk);
    do_load(8'h50, 8'h51);
    repeat (T - 1) @(negedge clk);
    chk("R7 timer restarted", {22'h0, pend_l, pend_r, gain_l}, 32'h330);
    exp_l.push_back(8'h50); exp_r.push_back(8'h51);
    @(negedge clk);
    chk("R7 timeout after reload", {16'h0, gain_l, gain_r}, 32'h5051);

    // idle crossings ignored
    flip(1'b0); flip(1'b0);
    chk("R5 idle crossings no effect", {23'h0, pend_l, gain_l}, 32'h050);
    do_load(8'h60, 8'h61);
    flip(1'b0);
    chk("R5 idle crossings not carried", {23'h0, pend_l, gain_l}, 32'h150);
    exp_l.push_back(8'h60);
    flip(1'b0);
    chk("R4 applied after second", {24'h0, gain_l}, 32'h60);
    exp_r.push_back(8'h61);
    repeat (T) @(negedge clk);

    // enable drop flushes pending
    do_load(8'h70, 8'h71);
    chk("R3 pend before drop", {30'h0, pend_l, pend_r}, 32'h3);
    exp_l.push_back(8'h70); exp_r.push_back(8'h71);
    zc_en = 1'b0;
    @(negedge clk);
    chk("R10 flushed on enable drop", {16'h0, gain_l, gain_r}, 32'h7071);
    chk("R10 pend cleared", {30'h0, pend_l, pend_r}, 32'h0);

    repeat (3) @(negedge clk);
    chk("R4 no leftover expectations", exp_l.size() + exp_r.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule